// File: doc/BRIEF.md
# Bidirectional Cartridge DMA Engine

This block copies bytes between a main-memory space and a cartridge memory space. Software first loads a memory address register and a cartridge address register. It then starts a copy by writing a length value to one of two length registers. The register that receives the write sets the direction: one register runs memory-to-cartridge, the other runs cartridge-to-memory. Both memory spaces are reached through plain synchronous byte ports with a one-cycle read latency. The engine moves one byte per cycle.

Before the copy starts, the cartridge address is forced to an even value. The memory address is forced even and held inside the memory space. The length is trimmed when the memory address sits off an 8-byte boundary. The transfer is not reported complete at the end of the copy. Completion waits until a cycle count has passed since the start. That count comes from an external timing input and is sampled when the copy starts. At completion, both address registers move forward by the final length and an interrupt is raised. Software reads the interrupt from the status register and clears it with a status write.

Top module: `cdma_engine`

## Requirements
- R1: The transfer length is bits [23:0] of the length write plus one. Bits [31:24] are ignored. The final length can be read back at the same offset: 0x08 for memory-to-cartridge, 0x0C for cartridge-to-memory.
- R2: At start, the cartridge address has bit 0 cleared. The memory address is ANDed with (2^MEM_AW - 2).
- R3: Let k be bits [2:0] of the aligned memory address. When k is nonzero and the length is greater than k, the length becomes length minus k. Otherwise the length is unchanged.
- R4: A write at offset 0x08 copies memory to cartridge: cartridge byte (cart_base+i) receives memory byte (mem_base+i), for i from 0 to length-1.
- R5: A write at offset 0x0C copies cartridge to memory: memory byte (mem_base+i) receives cartridge byte (cart_base+i). Only one port is written during a copy.
- R6: After completion, the register at offset 0x00 holds aligned memory address plus length. The register at offset 0x04 holds aligned cartridge address plus length.
- R7: Status bit 0 (busy) stays set for exactly max(L+2, D+1) clock edges after the edge that captures the length write. L is the length and D is delay_cycles sampled at that edge.
- R8: At completion, irq rises and status bit 3 is set. The status register at offset 0x10 then reads exactly 0x8.
- R9: A status write with bit 1 set clears the interrupt. A status write with bit 1 clear leaves the interrupt unchanged.
- R10: Writes to either length register while busy are ignored. No second copy starts and neither length register changes.
- R11: Port addresses wrap modulo 2^MEM_AW for memory and modulo 2^CART_AW for the cartridge.
- R12: After reset, all readable registers are zero, irq is low and neither port is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| delay_cycles | input | DLY_W | Minimum cycles from start to completion |
| irq | output | 1 | Completion interrupt |
| mem_addr | output | MEM_AW | Memory byte address |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, one cycle after address |
| cart_addr | output | CART_AW | Cartridge byte address |
| cart_wr | output | 1 | Cartridge write strobe |
| cart_wdata | output | 8 | Cartridge write byte |
| cart_rdata | input | 8 | Cartridge read byte, one cycle after address |

## Verification
The bench builds the engine with MEM_AW=8, CART_AW=7 and DLY_W=8. This gives a 256-byte memory and a 128-byte cartridge that the bench models in full. Copies placed near the top of each space run across both wrap points in a single transfer. The 8-bit delay lets some cases finish when the copy ends and others wait on the delay, so both terms of the completion time are tested.

// File: rtl/cdma_pkg.sv
package cdma_pkg;
    localparam int LEN_W = 25;

    localparam logic [4:0] OFS_MEM   = 5'h00;
    localparam logic [4:0] OFS_CART  = 5'h04;
    localparam logic [4:0] OFS_RDLEN = 5'h08;
    localparam logic [4:0] OFS_WRLEN = 5'h0C;
    localparam logic [4:0] OFS_STAT  = 5'h10;

    typedef enum logic {DIR_M2C, DIR_C2M} dir_e;
    typedef enum logic {MV_IDLE, MV_RUN} mv_state_e;
endpackage

// File: rtl/cdma_len_calc.sv
module cdma_len_calc
    import cdma_pkg::*;
#(
    parameter int MEM_AW = 23
) (
    input  logic [23:0]      len_field,
    input  logic [31:0]      mem_reg,
    input  logic [31:0]      cart_reg,
    output logic [LEN_W-1:0] len,
    output logic [31:0]      mem_al,
    output logic [31:0]      cart_al
);
    localparam logic [31:0] MEM_MASK = (32'd1 << MEM_AW) - 32'd2;

    logic [LEN_W-1:0] raw;
    logic [2:0]       skew;

    always_comb begin
        mem_al  = mem_reg & MEM_MASK;
        cart_al = {cart_reg[31:1], 1'b0};
        raw     = {1'b0, len_field} + LEN_W'(1);
        skew    = mem_al[2:0];
        len     = raw;
        if (skew != 3'd0 && raw > LEN_W'(skew)) begin
            len = raw - LEN_W'(skew);
        end
    end
endmodule

// File: rtl/cdma_mover.sv
module cdma_mover
    import cdma_pkg::*;
#(
    parameter int MEM_AW  = 23,
    parameter int CART_AW = 16,
    parameter int DLY_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  dir_e               start_dir,
    input  logic [DLY_W-1:0]   delay,
    input  logic [LEN_W-1:0]   len,
    input  logic [31:0]        mem_base,
    input  logic [31:0]        cart_base,
    output logic               busy,
    output logic               done,
    output logic [MEM_AW-1:0]  mem_addr,
    output logic               mem_wr,
    output logic [7:0]         mem_wdata,
    input  logic [7:0]         mem_rdata,
    output logic [CART_AW-1:0] cart_addr,
    output logic               cart_wr,
    output logic [7:0]         cart_wdata,
    input  logic [7:0]         cart_rdata
);
    typedef struct packed {
        mv_state_e        state;
        dir_e             dir;
        logic [LEN_W-1:0] rd_cnt;
        logic             wv;
        logic [LEN_W-1:0] w_idx;
        logic [DLY_W-1:0] dly_cnt;
        logic [DLY_W-1:0] dly_tgt;
    } mv_t;

    mv_t q, d;
    logic rd_go;
    logic copy_done;

    always_comb begin
        d         = q;
        done      = 1'b0;
        rd_go     = (q.state == MV_RUN) && (q.rd_cnt < len);
        copy_done = !rd_go && !q.wv;

        if (q.dir == DIR_M2C) begin
            mem_addr  = MEM_AW'(mem_base + 32'(q.rd_cnt));
            cart_addr = CART_AW'(cart_base + 32'(q.w_idx));
            cart_wr   = (q.state == MV_RUN) && q.wv;
            mem_wr    = 1'b0;
        end else begin
            cart_addr = CART_AW'(cart_base + 32'(q.rd_cnt));
            mem_addr  = MEM_AW'(mem_base + 32'(q.w_idx));
            mem_wr    = (q.state == MV_RUN) && q.wv;
            cart_wr   = 1'b0;
        end
        cart_wdata = mem_rdata;
        mem_wdata  = cart_rdata;

        case (q.state)
            MV_IDLE: begin
                if (start) begin
                    d.state   = MV_RUN;
                    d.dir     = start_dir;
                    d.rd_cnt  = '0;
                    d.wv      = 1'b0;
                    d.w_idx   = '0;
                    d.dly_cnt = '0;
                    d.dly_tgt = delay;
                end
            end
            MV_RUN: begin
                d.wv    = rd_go;
                d.w_idx = q.rd_cnt;
                if (rd_go) begin
                    d.rd_cnt = q.rd_cnt + LEN_W'(1);
                end
                if (q.dly_cnt != q.dly_tgt) begin
                    d.dly_cnt = q.dly_cnt + DLY_W'(1);
                end
                if (copy_done && q.dly_cnt == q.dly_tgt) begin
                    done    = 1'b1;
                    d.state = MV_IDLE;
                end
            end
            default: d.state = MV_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{state: MV_IDLE, dir: DIR_M2C, default: '0};
        end else begin
            q <= d;
        end
    end

    assign busy = (q.state == MV_RUN);
endmodule

// File: rtl/cdma_engine.sv
module cdma_engine
    import cdma_pkg::*;
#(
    parameter int MEM_AW  = 23,
    parameter int CART_AW = 16,
    parameter int DLY_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [4:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [DLY_W-1:0]   delay_cycles,
    output logic               irq,
    output logic [MEM_AW-1:0]  mem_addr,
    output logic               mem_wr,
    output logic [7:0]         mem_wdata,
    input  logic [7:0]         mem_rdata,
    output logic [CART_AW-1:0] cart_addr,
    output logic               cart_wr,
    output logic [7:0]         cart_wdata,
    input  logic [7:0]         cart_rdata
);
    typedef struct packed {
        logic [31:0]      mem_reg;
        logic [31:0]      cart_reg;
        logic [LEN_W-1:0] rdlen;
        logic [LEN_W-1:0] wrlen;
        logic [31:0]      mem_base;
        logic [31:0]      cart_base;
        logic [LEN_W-1:0] xlen;
        logic             irq;
    } eng_t;

    eng_t q, d;

    logic [LEN_W-1:0] calc_len;
    logic [31:0]      calc_mem_al;
    logic [31:0]      calc_cart_al;
    logic             mv_start;
    dir_e             mv_dir;
    logic             mv_busy;
    logic             mv_done;

    cdma_len_calc #(.MEM_AW(MEM_AW)) u_len (
        .len_field (reg_wdata[23:0]),
        .mem_reg   (q.mem_reg),
        .cart_reg  (q.cart_reg),
        .len       (calc_len),
        .mem_al    (calc_mem_al),
        .cart_al   (calc_cart_al)
    );

    cdma_mover #(.MEM_AW(MEM_AW), .CART_AW(CART_AW), .DLY_W(DLY_W)) u_mv (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (mv_start),
        .start_dir  (mv_dir),
        .delay      (delay_cycles),
        .len        (q.xlen),
        .mem_base   (q.mem_base),
        .cart_base  (q.cart_base),
        .busy       (mv_busy),
        .done       (mv_done),
        .mem_addr   (mem_addr),
        .mem_wr     (mem_wr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .cart_addr  (cart_addr),
        .cart_wr    (cart_wr),
        .cart_wdata (cart_wdata),
        .cart_rdata (cart_rdata)
    );

    always_comb begin
        d        = q;
        mv_start = 1'b0;
        mv_dir   = DIR_M2C;

        if (reg_wr) begin
            case (reg_addr)
                OFS_MEM:  d.mem_reg  = reg_wdata;
                OFS_CART: d.cart_reg = reg_wdata;
                OFS_RDLEN, OFS_WRLEN: begin
                    if (!mv_busy) begin
                        mv_start    = 1'b1;
                        mv_dir      = (reg_addr == OFS_RDLEN) ? DIR_M2C : DIR_C2M;
                        d.mem_base  = calc_mem_al;
                        d.cart_base = calc_cart_al;
                        d.xlen      = calc_len;
                        if (reg_addr == OFS_RDLEN) begin
                            d.rdlen = calc_len;
                        end else begin
                            d.wrlen = calc_len;
                        end
                    end
                end
                OFS_STAT: begin
                    if (reg_wdata[1]) begin
                        d.irq = 1'b0;
                    end
                end
                default: ;
            endcase
        end

        if (mv_done) begin
            d.irq      = 1'b1;
            d.mem_reg  = q.mem_base + 32'(q.xlen);
            d.cart_reg = q.cart_base + 32'(q.xlen);
        end

        case (reg_addr)
            OFS_MEM:   reg_rdata = q.mem_reg;
            OFS_CART:  reg_rdata = q.cart_reg;
            OFS_RDLEN: reg_rdata = 32'(q.rdlen);
            OFS_WRLEN: reg_rdata = 32'(q.wrlen);
            OFS_STAT:  reg_rdata = {28'd0, q.irq, 2'b00, mv_busy};
            default:   reg_rdata = 32'd0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign irq = q.irq;
endmodule

// File: rtl/cdma_chk.sv
module cdma_chk
    import cdma_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [4:0]       reg_addr,
    input logic             clr_bit,
    input logic             irq,
    input logic             busy,
    input logic             done,
    input logic             mem_wr,
    input logic             cart_wr,
    input logic [LEN_W-1:0] rdlen,
    input logic [LEN_W-1:0] wrlen
);
    logic clr_req;
    assign clr_req = reg_wr && (reg_addr == OFS_STAT) && clr_bit;

    p_wr_in_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr || cart_wr) |-> busy);

    p_single_port_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr && cart_wr));

    p_done_sets_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> irq);

    p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(done));

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !done) |=> !irq);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_req) |=> irq);

    p_rdlen_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(rdlen));

    p_wrlen_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(wrlen));
endmodule

bind cdma_engine cdma_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .clr_bit  (reg_wdata[1]),
    .irq      (irq),
    .busy     (mv_busy),
    .done     (mv_done),
    .mem_wr   (mem_wr),
    .cart_wr  (cart_wr),
    .rdlen    (q.rdlen),
    .wrlen    (q.wrlen)
);

// File: tb/sim_cdma_engine.sv
module sim_cdma_engine;
    localparam int MEM_AW  = 8;
    localparam int CART_AW = 7;
    localparam int DLY_W   = 8;
    localparam int MSZ = 1 << MEM_AW;
    localparam int CSZ = 1 << CART_AW;

    typedef struct packed {
        logic        dir;
        logic [31:0] ma;
        logic [31:0] ca;
        logic [31:0] lf;
        logic [7:0]  dly;
        logic [31:0] len;
        logic [31:0] cyc;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'h10, 32'h20, 32'hAB000003, 8'd2,  32'd4, 32'd6},
        '{1'b1, 32'h13, 32'h05, 32'h00000007, 8'd20, 32'd6, 32'd21},
        '{1'b0, 32'h06, 32'h41, 32'h00000004, 8'd0,  32'd5, 32'd7},
        '{1'b1, 32'hFC, 32'h7C, 32'h00000009, 8'd8,  32'd6, 32'd9},
        '{1'b0, 32'hF8, 32'h7F, 32'h00000000, 8'd3,  32'd1, 32'd4},
        '{1'b0, 32'h04, 32'h00, 32'h00000003, 8'd0,  32'd4, 32'd6}
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               reg_wr = 1'b0;
    logic [4:0]         reg_addr = 5'h0;
    logic [31:0]        reg_wdata = 32'h0;
    logic [31:0]        reg_rdata;
    logic [DLY_W-1:0]   delay_cycles = '0;
    logic               irq;
    logic [MEM_AW-1:0]  mem_addr;
    logic               mem_wr;
    logic [7:0]         mem_wdata;
    logic [7:0]         mem_rdata;
    logic [CART_AW-1:0] cart_addr;
    logic               cart_wr;
    logic [7:0]         cart_wdata;
    logic [7:0]         cart_rdata;

    always #5 clk = ~clk;

    cdma_engine #(.MEM_AW(MEM_AW), .CART_AW(CART_AW), .DLY_W(DLY_W)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .delay_cycles(delay_cycles),
        .irq(irq), .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .cart_addr(cart_addr), .cart_wr(cart_wr),
        .cart_wdata(cart_wdata), .cart_rdata(cart_rdata)
    );

    logic [7:0] bm [MSZ];
    logic [7:0] bc [CSZ];
    logic       load = 1'b0;
    int         seed = 0;
    int         mem_wc = 0;
    int         cart_wc = 0;

    function automatic logic [7:0] mpat(int a, int s);
        return 8'((a * 7) + (s * 13) + 1);
    endfunction
    function automatic logic [7:0] cpat(int a, int s);
        return 8'((a * 11) + (s * 5) + 3);
    endfunction

    always @(posedge clk) begin
        if (load) begin
            for (int i = 0; i < MSZ; i++) bm[i] <= mpat(i, seed);
            for (int i = 0; i < CSZ; i++) bc[i] <= cpat(i, seed);
            mem_wc  <= 0;
            cart_wc <= 0;
        end else begin
            if (mem_wr) begin
                bm[mem_addr] <= mem_wdata;
                mem_wc <= mem_wc + 1;
            end
            if (cart_wr) begin
                bc[cart_addr] <= cart_wdata;
                cart_wc <= cart_wc + 1;
            end
        end
        mem_rdata  <= bm[mem_addr];
        cart_rdata <= bc[cart_addr];
    end

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_wr   = 1'b0;
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = v;
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
    endtask

    task automatic reload(input int s);
        @(negedge clk);
        seed = s;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    // Start a copy and count edges (after the capturing edge) during which busy stays high
    task automatic start_timed(input logic [4:0] a, input logic [31:0] v, output int n);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = v;
        n = 0;
        forever begin
            @(negedge clk);
            reg_wr   = 1'b0;
            reg_addr = 5'h10;
            #1;
            if (reg_rdata[0] && n < 1000) n++;
            else break;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int n;
        int bad;

        reload(99);
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R12: reset state
        rd(5'h00, v); chk(v == 0, "R12 mem reg", v, 0);
        rd(5'h04, v); chk(v == 0, "R12 cart reg", v, 0);
        rd(5'h08, v); chk(v == 0, "R12 rdlen", v, 0);
        rd(5'h0C, v); chk(v == 0, "R12 wrlen", v, 0);
        rd(5'h10, v); chk(v == 0, "R12 status", v, 0);
        chk(irq == 1'b0, "R12 irq", irq, 0);
        chk(mem_wc == 0 && cart_wc == 0, "R12 no writes", mem_wc + cart_wc, 0);

        for (int k = 0; k < NV; k++) begin
            int mb, cb, sb, db;
            reload(k);
            wr(5'h00, VECS[k].ma);
            wr(5'h04, VECS[k].ca);
            delay_cycles = VECS[k].dly;
            start_timed(VECS[k].dir ? 5'h0C : 5'h08, VECS[k].lf, n);
            // R7: busy duration
            chk(n == int'(VECS[k].cyc), $sformatf("R7 v%0d cycles", k), n, VECS[k].cyc);
            // R8: interrupt and status
            chk(irq == 1'b1, $sformatf("R8 v%0d irq", k), irq, 1);
            rd(5'h10, v); chk(v == 32'h8, $sformatf("R8 v%0d status", k), v, 32'h8);
            // R1 / R3: length read back
            rd(VECS[k].dir ? 5'h0C : 5'h08, v);
            chk(v == VECS[k].len, $sformatf("R1 R3 v%0d length", k), v, VECS[k].len);
            // R2 / R6: address registers
            mb = int'(VECS[k].ma & 32'hFE);
            cb = int'(VECS[k].ca & 32'hFFFF_FFFE);
            rd(5'h00, v);
            chk(v == 32'(mb) + VECS[k].len, $sformatf("R2 R6 v%0d mem reg", k), v, 32'(mb) + VECS[k].len);
            rd(5'h04, v);
            chk(v == 32'(cb) + VECS[k].len, $sformatf("R2 R6 v%0d cart reg", k), v, 32'(cb) + VECS[k].len);
            // R4 / R5 / R11: data and write counts
            bad = 0;
            for (int i = 0; i < int'(VECS[k].len); i++) begin
                if (VECS[k].dir == 1'b0) begin
                    sb = (mb + i) % MSZ; db = (cb + i) % CSZ;
                    if (bc[db] != mpat(sb, k)) bad++;
                end else begin
                    sb = (cb + i) % CSZ; db = (mb + i) % MSZ;
                    if (bm[db] != cpat(sb, k)) bad++;
                end
            end
            chk(bad == 0, $sformatf("R4 R5 R11 v%0d data mismatches", k), bad, 0);
            if (VECS[k].dir == 1'b0)
                chk(cart_wc == int'(VECS[k].len) && mem_wc == 0, $sformatf("R4 v%0d writes", k), cart_wc * 1000 + mem_wc, VECS[k].len * 1000);
            else
                chk(mem_wc == int'(VECS[k].len) && cart_wc == 0, $sformatf("R5 v%0d writes", k), mem_wc * 1000 + cart_wc, VECS[k].len * 1000);
            wr(5'h10, 32'h2);
        end

        // R9: clear semantics
        reload(7);
        wr(5'h00, 32'h40);
        wr(5'h04, 32'h10);
        delay_cycles = 8'd0;
        start_timed(5'h08, 32'h1, n);
        wr(5'h10, 32'h1);
        rd(5'h10, v); chk(v == 32'h8, "R9 write without bit1 keeps irq", v, 32'h8);
        chk(irq == 1'b1, "R9 irq kept", irq, 1);
        wr(5'h10, 32'h2);
        rd(5'h10, v); chk(v == 32'h0, "R9 write bit1 clears", v, 0);
        chk(irq == 1'b0, "R9 irq cleared", irq, 0);

        // R10: length writes while busy are ignored
        reload(8);
        rd(5'h0C, v);
        begin
            logic [31:0] wr_before;
            wr_before = v;
            wr(5'h00, 32'h30);
            wr(5'h04, 32'h10);
            delay_cycles = 8'd0;
            wr(5'h08, 32'h0F);
            wr(5'h0C, 32'h3);
            wr(5'h08, 32'h1);
            n = 0;
            forever begin
                rd(5'h10, v);
                if (v[0] && n < 1000) n++;
                else break;
            end
            rd(5'h08, v); chk(v == 32'd16, "R10 rdlen unchanged", v, 16);
            rd(5'h0C, v); chk(v == wr_before, "R10 wrlen unchanged", v, wr_before);
            chk(cart_wc == 16 && mem_wc == 0, "R10 single copy", cart_wc * 1000 + mem_wc, 16000);
            rd(5'h00, v); chk(v == 32'h40, "R10 mem reg", v, 32'h40);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule